// File: doc/BRIEF.md
# Parallel BCH Syndrome Calculator

This block takes a whole received binary word of a BCH code in a single beat and returns every syndrome the decoder can use. Syndrome S_i is the word, read as a polynomial over GF(2), evaluated at the i-th power of the primitive field element. The field element is the one fixed by a primitive polynomial of degree GF_M. All evaluations happen at once as one constant product over GF(2): each output bit is the parity of the input word masked with a fixed pattern. The patterns are derived at elaboration time from the field parameters.

The unit always produces 2*T_MAX syndromes, enough for the strongest correction setting that the design supports. A decoder running at a weaker setting simply ignores the higher syndromes, so there is no configuration input and no selection logic. A word is offered with `cw_valid`. Its syndromes appear in a register one clock later, flagged by `syn_valid`, and they stay there until the next word is accepted. A new word may be offered on every cycle.

Top module: `bch_syndrome_par`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and on the first edge after its release, `syn_valid` is 0 and `syn_vec` is all zero.
- R2: `syn_valid` is 1 in exactly the cycle after an edge that sampled `cw_valid` high, and 0 after an edge that sampled it low.
- R3: Bit j of `cw_bits` is the coefficient of x^j. Syndrome S_i (i = 1..2*T_MAX) occupies `syn_vec[(i-1)*GF_M +: GF_M]` and equals the GF(2^GF_M) sum of alpha^(i*j) over every j where bit j is 1. Field elements are in polynomial basis, with bit k being the coefficient of alpha^k. An all-zero word gives all-zero syndromes.
- R4: Every codeword of the T_MAX-error-correcting BCH code gives all-zero syndromes. This includes multiples of the generator polynomial and the all-ones word of length 2^GF_M-1.
- R5: A word with a single 1 at position j gives S_i = alpha^(i*j mod (2^GF_M-1)) for every i. A codeword with one flipped bit gives the same result.
- R6: After a cycle in which `cw_valid` is 0, `syn_vec` keeps its previous value.
- R7: Every accepted result satisfies S_(2i) = S_i squared in the field, for i = 1..T_MAX.
- R8: Words offered on consecutive cycles each produce their own result, in order, with no gap and no lost word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_valid | input | 1 | Strobe: `cw_bits` holds a word to evaluate |
| cw_bits | input | N | Received word, bit j = coefficient of x^j |
| syn_valid | output | 1 | Strobe: `syn_vec` holds fresh syndromes |
| syn_vec | output | 2*T_MAX*GF_M | Syndromes S_1..S_2T, S_i in field slot i-1 |

## Verification
The hardest case to reach from the ports is a nonzero word whose syndromes must all vanish. Random patterns almost never land on a codeword. The bench therefore builds the generator polynomial on its own, as the product of the linear factors for the conjugacy classes of alpha, alpha^3 and alpha^5. It then sends GF(2) multiples of that polynomial, plus the all-ones word. Single-error words built on those codewords check the position mapping. Streams of back-to-back words followed by idle gaps check the ordering and the hold behaviour.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

   localparam int GFW = 16;

   // multiply a field element by alpha, reducing with the primitive polynomial
   function automatic logic [GFW-1:0] gf_mulx(logic [GFW-1:0] a, int m, logic [GFW-1:0] poly);
      logic [GFW-1:0] t;
      t = a << 1;
      if (t[m]) t = t ^ poly;
      return t;
   endfunction

   // alpha raised to the exponent e
   function automatic logic [GFW-1:0] gf_alpha_pow(int e, int m, logic [GFW-1:0] poly);
      logic [GFW-1:0] acc;
      int order;
      order = (1 << m) - 1;
      acc = 1;
      for (int k = 0; k < (e % order); k++) acc = gf_mulx(acc, m, poly);
      return acc;
   endfunction

   // general product of two field elements
   function automatic logic [GFW-1:0] gf_mul(logic [GFW-1:0] a, logic [GFW-1:0] b, int m,
                                             logic [GFW-1:0] poly);
      logic [GFW-1:0] acc;
      acc = '0;
      for (int k = m - 1; k >= 0; k--) begin
         acc = gf_mulx(acc, m, poly);
         if (b[k]) acc = acc ^ a;
      end
      return acc;
   endfunction

endpackage

// File: rtl/syn_lane.sv
module syn_lane #(
   parameter int GF_M      = 5,
   parameter int N         = 31,
   parameter int PRIM_POLY = 37,
   parameter int IDX       = 1
) (
   input  logic [N-1:0]    cw,
   output logic [GF_M-1:0] syn
);
   import bch_syn_pkg::*;

   localparam logic [GFW-1:0] POLY16 = GFW'(PRIM_POLY);

   // positions whose alpha^(IDX*j) has bit b set
   function automatic logic [N-1:0] col_mask(int b);
      logic [N-1:0]   msk;
      logic [GFW-1:0] p;
      for (int j = 0; j < N; j++) begin
         p = gf_alpha_pow(IDX * j, GF_M, POLY16);
         msk[j] = p[b];
      end
      return msk;
   endfunction

   for (genvar b = 0; b < GF_M; b++) begin : g_bit
      localparam logic [N-1:0] MSK = col_mask(b);
      assign syn[b] = ^(cw & MSK);
   end

endmodule

// File: rtl/syn_out_stage.sv
module syn_out_stage #(
   parameter int W = 30
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q       <= '0;
      end else begin
         q_valid <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/bch_syndrome_par.sv
module bch_syndrome_par #(
   parameter int GF_M      = 5,
   parameter int N         = 31,
   parameter int T_MAX     = 3,
   parameter int PRIM_POLY = 37
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cw_valid,
   input  logic [N-1:0]              cw_bits,
   output logic                      syn_valid,
   output logic [2*T_MAX*GF_M-1:0]   syn_vec
);
   localparam int NSYN  = 2 * T_MAX;
   localparam int SW    = NSYN * GF_M;
   localparam int ORDER = (1 << GF_M) - 1;

   if (GF_M < 2 || GF_M > 15) begin : g_bad_m
      $error("GF_M must lie in 2..15");
   end
   if (N < 1 || N > ORDER) begin : g_bad_n
      $error("N must lie in 1..2^GF_M-1");
   end
   if (T_MAX < 1 || NSYN >= ORDER) begin : g_bad_t
      $error("T_MAX out of range for the field");
   end
   if (((PRIM_POLY >> GF_M) != 1) || ((PRIM_POLY & 1) != 1)) begin : g_bad_poly
      $error("PRIM_POLY must have degree GF_M and a constant term");
   end

   logic [SW-1:0] syn_comb;

   for (genvar i = 1; i <= NSYN; i++) begin : g_lane
      syn_lane #(
         .GF_M(GF_M), .N(N), .PRIM_POLY(PRIM_POLY), .IDX(i)
      ) u_lane (
         .cw  (cw_bits),
         .syn (syn_comb[(i-1)*GF_M +: GF_M])
      );
   end

   syn_out_stage #(.W(SW)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cw_valid),
      .d       (syn_comb),
      .q_valid (syn_valid),
      .q       (syn_vec)
   );

endmodule

// File: rtl/bch_syndrome_chk.sv
module bch_syndrome_chk #(
   parameter int GF_M      = 5,
   parameter int N         = 31,
   parameter int T_MAX     = 3,
   parameter int PRIM_POLY = 37
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cw_valid,
   input logic [N-1:0]            cw_bits,
   input logic                    syn_valid,
   input logic [2*T_MAX*GF_M-1:0] syn_vec
);
   import bch_syn_pkg::*;

   localparam logic [GFW-1:0] POLY16 = GFW'(PRIM_POLY);

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!syn_valid && syn_vec == '0));

   // R2 / R8
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |=> syn_valid);
   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cw_valid |=> !syn_valid);

   // R6
   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cw_valid |=> $stable(syn_vec));

   // R3
   p_zero_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && cw_bits == '0) |=> (syn_vec == '0));

   // R7
   for (genvar i = 1; i <= T_MAX; i++) begin : g_conj
      logic [GFW-1:0] s_lo, s_hi, s_sq;
      assign s_lo = GFW'(syn_vec[(i-1)*GF_M +: GF_M]);
      assign s_hi = GFW'(syn_vec[(2*i-1)*GF_M +: GF_M]);
      assign s_sq = gf_mul(s_lo, s_lo, GF_M, POLY16);
      p_conjugate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         syn_valid |-> (s_sq == s_hi));
   end

endmodule

bind bch_syndrome_par bch_syndrome_chk #(
   .GF_M(GF_M), .N(N), .T_MAX(T_MAX), .PRIM_POLY(PRIM_POLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_bits(cw_bits),
   .syn_valid(syn_valid), .syn_vec(syn_vec)
);

// File: tb/sim_bch_syndrome_par.sv
module sim_bch_syndrome_par;
   localparam int M  = 5;
   localparam int N  = 31;
   localparam int T  = 3;
   localparam int NS = 2 * T;
   localparam int SW = NS * M;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cw_valid = 1'b0;
   logic [N-1:0]  cw_bits = '0;
   logic          syn_valid;
   logic [SW-1:0] syn_vec;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   logic [SW-1:0] exp_q[$];
   string         tag_q[$];
   logic [SW-1:0] last_vec = '0;
   logic          cap_valid;
   logic [15:0]   gbits;
   logic [31:0]   rng = 32'h1234_5677;

   always #2.5 clk = ~clk;

   bch_syndrome_par u0 (
      .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_bits(cw_bits),
      .syn_valid(syn_valid), .syn_vec(syn_vec)
   );

   // ---------------- independent field model (x^5 + x^2 + 1)
   function automatic logic [4:0] bmulx(logic [4:0] a);
      logic [5:0] t;
      t = {a, 1'b0};
      if (t[5]) t = t ^ 6'h25;
      return t[4:0];
   endfunction

   function automatic logic [4:0] bmul(logic [4:0] a, logic [4:0] b);
      logic [4:0] r;
      r = '0;
      for (int k = 0; k < 5; k++) begin
         if (b[k]) r = r ^ a;
         a = bmulx(a);
      end
      return r;
   endfunction

   function automatic logic [4:0] bpow(int e);
      logic [4:0] r;
      r = 5'd1;
      for (int k = 0; k < (e % 31); k++) r = bmulx(r);
      return r;
   endfunction

   // Horner evaluation of the word at alpha^i
   function automatic logic [SW-1:0] model_syn(logic [N-1:0] w);
      logic [SW-1:0] v;
      logic [4:0] beta, acc;
      for (int i = 1; i <= NS; i++) begin
         beta = bpow(i);
         acc = '0;
         for (int j = N - 1; j >= 0; j--) acc = bmul(acc, beta) ^ {4'b0, w[j]};
         v[(i-1)*M +: M] = acc;
      end
      return v;
   endfunction

   function automatic logic [SW-1:0] single_err(int j);
      logic [SW-1:0] v;
      for (int i = 1; i <= NS; i++) v[(i-1)*M +: M] = bpow(i * j);
      return v;
   endfunction

   // generator polynomial: product of (x + alpha^e) over three conjugacy classes
   task automatic build_gen();
      int roots[15] = '{1, 2, 4, 8, 16, 3, 6, 12, 24, 17, 5, 10, 20, 9, 18};
      logic [4:0] g[16];
      for (int k = 0; k < 16; k++) g[k] = '0;
      g[0] = 5'd1;
      for (int r = 0; r < 15; r++) begin
         for (int k = r + 1; k >= 1; k--) g[k] = g[k-1] ^ bmul(g[k], bpow(roots[r]));
         g[0] = bmul(g[0], bpow(roots[r]));
      end
      for (int k = 0; k < 16; k++) gbits[k] = g[k][0];
   endtask

   function automatic logic [N-1:0] make_cw(logic [15:0] a);
      logic [N-1:0] c;
      c = '0;
      for (int k = 0; k < 16; k++) if (a[k]) c = c ^ (N'(gbits) << k);
      return c;
   endfunction

   function automatic logic [31:0] next_rng(logic [31:0] s);
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      return s;
   endfunction

   // ---------------- driver
   task automatic send(logic [N-1:0] w, logic [SW-1:0] exp, string tag);
      @(negedge clk);
      cw_valid = 1'b1;
      cw_bits  = w;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cw_valid = 1'b0;
         cw_bits  = ~cw_bits;
      end
   endtask

   task automatic check(bit ok, string req, logic [SW-1:0] act, logic [SW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- monitor
   always @(posedge clk or negedge rst_n)
      if (!rst_n) cap_valid <= 1'b0;
      else        cap_valid <= cw_valid;

   always @(negedge clk) begin
      if (rst_n) begin
         check(syn_valid == cap_valid, "R2 valid timing", SW'(syn_valid), SW'(cap_valid));
         if (syn_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected result", syn_vec, '0);
            end else begin
               logic [SW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(syn_vec == e, t, syn_vec, e);
               for (int i = 1; i <= T; i++)
                  check(bmul(syn_vec[(i-1)*M +: M], syn_vec[(i-1)*M +: M]) ==
                        syn_vec[(2*i-1)*M +: M], "R7 conjugate square",
                        SW'(syn_vec[(2*i-1)*M +: M]),
                        SW'(bmul(syn_vec[(i-1)*M +: M], syn_vec[(i-1)*M +: M])));
            end
            last_vec <= syn_vec;
         end else begin
            check(syn_vec == last_vec, "R6 hold while idle", syn_vec, last_vec);
         end
      end
   end

   // ---------------- stimulus
   initial begin
      logic [N-1:0] w;
      build_gen();
      repeat (3) @(negedge clk);
      check(syn_valid == 1'b0 && syn_vec == '0, "R1 reset state", syn_vec, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(syn_valid == 1'b0 && syn_vec == '0, "R1 after release", syn_vec, '0);

      // R3 zero word and general patterns
      send('0, '0, "R3 zero word");
      idle(2);
      send(N'(1), single_err(0), "R3 x^0 only");
      idle(1);
      for (int k = 0; k < 20; k++) begin
         rng = next_rng(rng);
         send(rng[N-1:0], model_syn(rng[N-1:0]), "R3 random word");
         idle(k % 3);
      end

      // R4 codewords
      send(make_cw(16'h0001), '0, "R4 generator itself");
      send({N{1'b1}}, '0, "R4 all-ones word");
      for (int k = 0; k < 10; k++) begin
         rng = next_rng(rng);
         send(make_cw(rng[15:0]), '0, "R4 multiple of generator");
      end
      idle(3);

      // R5 single errors, bare and on codewords
      for (int j = 0; j < N; j++) begin
         send(N'(1) << j, single_err(j), "R5 single error");
         if (j % 4 == 0) idle(1);
      end
      for (int k = 0; k < 8; k++) begin
         rng = next_rng(rng);
         w = make_cw(rng[15:0]) ^ (N'(1) << (rng[20:16] % N));
         send(w, single_err(int'(rng[20:16] % N)), "R5 error on codeword");
      end
      idle(2);

      // R8 long back-to-back stream, then R6 idle gap
      for (int k = 0; k < 40; k++) begin
         rng = next_rng(rng);
         send(rng[N-1:0], model_syn(rng[N-1:0]), "R8 back-to-back stream");
      end
      idle(6);

      check(exp_q.size() == 0, "R8 all results returned", SW'(exp_q.size()), '0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
         $finish;
      end
   end

endmodule